// File: doc/BRIEF.md
# Programmable Flag Offset Register Loader

This block keeps the two threshold offsets that a FIFO's almost-empty and almost-full comparators use: an empty-side offset and a full-side offset. A master reset loads both with the same preset value, picked from eight choices by a three-bit code. The same master reset also fixes how the offsets may be rewritten afterwards. In parallel mode, whole offsets are taken from the data input bus, one register per load cycle. In serial mode, offsets are shifted in one bit per enabled clock from a single serial input.

A separate read pointer returns the offsets on the data output bus one register at a time. This read-back works in either programming mode. The write pointer and the read pointer are independent. Each one alternates between the empty-side and the full-side register. A partial reset returns both pointers to the empty-side register and leaves the stored offsets and the chosen mode as they are. The current offsets are also driven continuously to the flag comparators, which lie outside this block.

Top module: `ofsLoader`

## Requirements
- R1: In a cycle with `mrst` high, both offsets are loaded with the preset selected by code = {`loadEn`, `presetSel[1:0]`}. The preset value is 2^(code+3)-1, saturated to all ones of the offset width. `dataOut` is cleared to 0 in the same cycle. All of this is visible one clock later.
- R2: The programming mode is sampled from `modeSerial` only in a cycle with `mrst` high (1 = serial, 0 = parallel). Changes of `modeSerial` at any other time have no effect.
- R3: In parallel mode, each cycle with `loadEn` and `wrEn` high writes `dataIn[OFS_W-1:0]` into the register at the write pointer. Bits of `dataIn` above the offset width are dropped. Writes alternate empty-side, full-side, empty-side, and so on. Each written value shows on the offset outputs one clock later.
- R4: In serial mode, cycles with `loadEn` and `wrEn` high leave both offsets unchanged. In either mode, `wrEn` without `loadEn` writes nothing.
- R5: In serial mode, each cycle with `serEn` high shifts in `serIn`. After 2*OFS_W such cycles, serial bit k (counted from 0) ends up in `emptyOffset[k]` for k < OFS_W and in `fullOffset[k-OFS_W]` otherwise. The empty-side offset is filled first, least significant bit first.
- R6: In parallel mode, `serEn` and `serIn` have no effect on either offset.
- R7: A cycle with `loadEn` and `rdEn` high places the register at the read pointer, zero-extended, on `dataOut` one clock later. The read pointer then moves on, alternating empty-side, full-side, with wrap. In all other cycles `dataOut` holds its value.
- R8: Offset read-back works in serial mode exactly as it does in parallel mode.
- R9: The read pointer and the write pointer advance independently. A read in the same cycle as a write to the same register returns the value held before that write.
- R10: A cycle with `prst` high (and `mrst` low) returns both pointers to the empty-side register. It performs no write and no read. It keeps the offsets, the mode and `dataOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| modeSerial | input | 1 | Mode choice sampled at master reset (1 = serial) |
| presetSel | input | 2 | Low two bits of the preset code at master reset |
| loadEn | input | 1 | Offset access qualifier; preset code bit 2 at master reset |
| wrEn | input | 1 | Write enable for parallel offset loading |
| rdEn | input | 1 | Read enable for offset read-back |
| serEn | input | 1 | Serial shift enable |
| serIn | input | 1 | Serial offset data bit |
| dataIn | input | DATA_W | Parallel offset data |
| dataOut | output | DATA_W | Read-back offset data |
| emptyOffset | output | OFS_W | Current almost-empty offset |
| fullOffset | output | OFS_W | Current almost-full offset |

## Verification
Each state bit of this block shows at the ports within one or two clocks. A stuck or wrongly toggled write pointer sends the second parallel write to the wrong register. That error shows on the offset outputs on the very next clock. A wrong read pointer or a missed partial reset shows up as the wrong offset on `dataOut` one clock after the read. A wrong mode latch becomes visible as soon as the first rejected or wrongly accepted write or shift changes an offset. The vectors therefore check the outputs after every cycle.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  // Strobes sent from the control block to the datapath, one set per cycle.
  typedef struct packed {
    logic       presetLoad;
    logic [2:0] presetCode;
    logic       wrEmpty;
    logic       wrFull;
    logic       shiftEn;
    logic       rdStrobe;
    logic       rdFull;
  } ofsStrobe_t;

  // Preset offset for a 3-bit code: 2^(code+3)-1, saturated to ofsW ones.
  function automatic int presetValue(input logic [2:0] code, input int ofsW);
    int sh;
    sh = int'(code) + 3;
    if (sh >= ofsW) return (1 << ofsW) - 1;
    return (1 << sh) - 1;
  endfunction

endpackage

// File: rtl/ofsCtrl.sv
module ofsCtrl
  import ofs_pkg::*;
(
  input  logic       clk,
  input  logic       mrst,
  input  logic       prst,
  input  logic       modeSerial,
  input  logic [1:0] presetSel,
  input  logic       loadEn,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       serEn,
  output ofsStrobe_t strobe
);

  logic serialMode;
  logic wrPtr;   // 0 = empty-side register, 1 = full-side register
  logic rdPtr;

  logic active;
  logic parWrite;

  always_comb begin
    active   = !mrst && !prst;
    parWrite = active && !serialMode && loadEn && wrEn;

    strobe            = '0;
    strobe.presetLoad = mrst;
    strobe.presetCode = {loadEn, presetSel};
    strobe.wrEmpty    = parWrite && !wrPtr;
    strobe.wrFull     = parWrite && wrPtr;
    strobe.shiftEn    = active && serialMode && serEn;
    strobe.rdStrobe   = active && loadEn && rdEn;
    strobe.rdFull     = rdPtr;
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      serialMode <= modeSerial;
      wrPtr      <= 1'b0;
      rdPtr      <= 1'b0;
    end else if (prst) begin
      wrPtr      <= 1'b0;
      rdPtr      <= 1'b0;
    end else begin
      if (parWrite)        wrPtr <= ~wrPtr;
      if (strobe.rdStrobe) rdPtr <= ~rdPtr;
    end
  end

endmodule

// File: rtl/ofsDatapath.sv
module ofsDatapath
  import ofs_pkg::*;
#(
  parameter int OFS_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  ofsStrobe_t        strobe,
  input  logic              serIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [OFS_W-1:0]  emptyOffset,
  output logic [OFS_W-1:0]  fullOffset
);

  localparam int CHAIN_W = 2 * OFS_W;

  logic [OFS_W-1:0]   emptyQ;
  logic [OFS_W-1:0]   fullQ;
  logic [DATA_W-1:0]  outQ;
  logic [CHAIN_W-1:0] chainNext;
  logic [OFS_W-1:0]   presetOfs;
  logic [OFS_W-1:0]   rdSel;

  always_comb begin
    presetOfs = OFS_W'(presetValue(strobe.presetCode, OFS_W));
    // Bits enter at the top of the chain and walk down toward emptyQ[0].
    chainNext = {serIn, fullQ, emptyQ[OFS_W-1:1]};
    rdSel     = strobe.rdFull ? fullQ : emptyQ;
  end

  always_ff @(posedge clk) begin
    if (strobe.presetLoad) begin
      emptyQ <= presetOfs;
      fullQ  <= presetOfs;
      outQ   <= '0;
    end else begin
      if (strobe.shiftEn) begin
        {fullQ, emptyQ} <= chainNext;
      end else begin
        if (strobe.wrEmpty) emptyQ <= dataIn[OFS_W-1:0];
        if (strobe.wrFull)  fullQ  <= dataIn[OFS_W-1:0];
      end
      if (strobe.rdStrobe) outQ <= DATA_W'(rdSel);
    end
  end

  assign dataOut     = outQ;
  assign emptyOffset = emptyQ;
  assign fullOffset  = fullQ;

endmodule

// File: rtl/ofsLoader.sv
module ofsLoader
  import ofs_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 16,
  parameter int OFS_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              modeSerial,
  input  logic [1:0]        presetSel,
  input  logic              loadEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              serEn,
  input  logic              serIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [OFS_W-1:0]  emptyOffset,
  output logic [OFS_W-1:0]  fullOffset
);

  ofsStrobe_t strobe;

  ofsCtrl uCtrl (
    .clk        (clk),
    .mrst       (mrst),
    .prst       (prst),
    .modeSerial (modeSerial),
    .presetSel  (presetSel),
    .loadEn     (loadEn),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .serEn      (serEn),
    .strobe     (strobe)
  );

  ofsDatapath #(.OFS_W(OFS_W), .DATA_W(DATA_W)) uData (
    .clk         (clk),
    .strobe      (strobe),
    .serIn       (serIn),
    .dataIn      (dataIn),
    .dataOut     (dataOut),
    .emptyOffset (emptyOffset),
    .fullOffset  (fullOffset)
  );

endmodule

// File: rtl/ofsLoaderChk.sv
module ofsLoaderChk #(
  parameter int DATA_W = 16,
  parameter int OFS_W  = 10
) (
  input logic              clk,
  input logic              mrst,
  input logic              prst,
  input logic              modeSerial,
  input logic              loadEn,
  input logic              wrEn,
  input logic              rdEn,
  input logic              serEn,
  input logic              serIn,
  input logic [DATA_W-1:0] dataOut,
  input logic [OFS_W-1:0]  emptyOffset,
  input logic [OFS_W-1:0]  fullOffset
);

  // The checker keeps its own copy of the mode, taken from the port at master reset.
  logic modeQ;
  always_ff @(posedge clk) if (mrst) modeQ <= modeSerial;

  // R1: after master reset both offsets are equal and dataOut is cleared
  assert_preset_equal_R1: assert property (@(posedge clk) disable iff (mrst)
    $past(mrst) |-> (emptyOffset == fullOffset) && (dataOut == '0));

  // R4: parallel-style writes never touch offsets in serial mode
  assert_serial_blocks_parallel_R4: assert property (@(posedge clk) disable iff (mrst)
    (modeQ && !serEn) |=> ($stable(emptyOffset) && $stable(fullOffset)));

  // R5: a serial shift moves bits one place down the empty/full chain
  assert_serial_shift_R5: assert property (@(posedge clk) disable iff (mrst)
    (modeQ && serEn && !prst) |=>
      (fullOffset[OFS_W-1] == $past(serIn)) && (emptyOffset[OFS_W-1] == $past(fullOffset[0])));

  // R6: without a loaded write, parallel mode keeps both offsets
  assert_parallel_ignores_serial_R6: assert property (@(posedge clk) disable iff (mrst)
    (!modeQ && !(loadEn && wrEn)) |=> ($stable(emptyOffset) && $stable(fullOffset)));

  // R7: dataOut holds unless a read is requested
  assert_readout_hold_R7: assert property (@(posedge clk) disable iff (mrst)
    !(loadEn && rdEn) |=> $stable(dataOut));

  // R7: a read always returns one of the two stored offsets
  assert_readout_source_R7: assert property (@(posedge clk) disable iff (mrst)
    (loadEn && rdEn && !prst) |=>
      (dataOut == DATA_W'($past(emptyOffset))) || (dataOut == DATA_W'($past(fullOffset))));

endmodule

bind ofsLoader ofsLoaderChk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) chk (
  .clk         (clk),
  .mrst        (mrst),
  .prst        (prst),
  .modeSerial  (modeSerial),
  .loadEn      (loadEn),
  .wrEn        (wrEn),
  .rdEn        (rdEn),
  .serEn       (serEn),
  .serIn       (serIn),
  .dataOut     (dataOut),
  .emptyOffset (emptyOffset),
  .fullOffset  (fullOffset)
);

// File: tb/tb_ofsLoader.sv
module tb_ofsLoader;

  localparam int OW = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          mrst, prst, modeSerial, loadEn, wrEn, rdEn, serEn, serIn;
  logic [1:0]    presetSel;
  logic [DW-1:0] dataIn;
  logic [DW-1:0] dataOut;
  logic [OW-1:0] emptyOffset, fullOffset;

  int vecCount  = 0;
  int failCount = 0;

  always #10 clk = ~clk;   // 50 MHz

  ofsLoader #(.DEPTH(1024), .DATA_W(DW)) dut (
    .clk(clk), .mrst(mrst), .prst(prst), .modeSerial(modeSerial),
    .presetSel(presetSel), .loadEn(loadEn), .wrEn(wrEn), .rdEn(rdEn),
    .serEn(serEn), .serIn(serIn), .dataIn(dataIn), .dataOut(dataOut),
    .emptyOffset(emptyOffset), .fullOffset(fullOffset)
  );

  typedef struct packed {
    logic mr, pr, ld, wr, rd, se, si;
    logic [DW-1:0] din;
    logic [OW-1:0] expE, expF;
    logic [DW-1:0] expQ;
  } vec_t;

  // Parallel mode, preset code 0 (value 7).
  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0000, 10'd7,   10'd7,   16'd0},   // R1 preset
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 16'h0055, 10'd85,  10'd7,   16'd0},   // R3 empty first
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 16'h0123, 10'd85,  10'd291, 16'd0},   // R3 full next
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 16'h0000, 10'd85,  10'd291, 16'd85},  // R7 read empty
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 16'h0000, 10'd85,  10'd291, 16'd291}, // R7 read full
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 16'h0000, 10'd85,  10'd291, 16'd85},  // R7 wrap
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 16'h03FF, 10'd85,  10'd291, 16'd85},  // R4 no loadEn
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 16'hFC00, 10'd0,   10'd291, 16'd85},  // R3 upper bits dropped
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0000, 10'd0,   10'd291, 16'd85},  // R10 partial reset
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 16'h02AA, 10'd682, 10'd291, 16'd85},  // R10 wr ptr back at empty
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 16'h0000, 10'd682, 10'd291, 16'd682}, // R10 rd ptr back at empty
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 16'h0011, 10'd682, 10'd17,  16'd291}, // R9 read old value
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 16'h0000, 10'd682, 10'd17,  16'd291}  // R6 serEn ignored
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    vecCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    mrst = 0; prst = 0; loadEn = 0; wrEn = 0; rdEn = 0; serEn = 0; serIn = 0; dataIn = '0;
  endtask

  // Inputs are set, then one rising edge passes; returns at the next falling edge.
  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic checkAll(input string req, input int e, input int f, input int q);
    check(req, "emptyOffset", int'(emptyOffset), e);
    check(req, "fullOffset",  int'(fullOffset),  f);
    check(req, "dataOut",     int'(dataOut),     q);
  endtask

  function automatic int expPreset(input int code);
    int v;
    v = (1 << (code + 3)) - 1;
    if (v > (1 << OW) - 1) v = (1 << OW) - 1;
    return v;
  endfunction

  initial begin
    #(20 * 150000);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    idle(); modeSerial = 0; presetSel = 2'b00;
    @(negedge clk);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      mrst = VEC[i].mr; prst = VEC[i].pr; loadEn = VEC[i].ld; wrEn = VEC[i].wr;
      rdEn = VEC[i].rd; serEn = VEC[i].se; serIn = VEC[i].si; dataIn = VEC[i].din;
      cyc();
      checkAll($sformatf("R3/R7 vec%0d", i), int'(VEC[i].expE), int'(VEC[i].expF), int'(VEC[i].expQ));
    end
    idle();

    // R1: all eight preset codes
    for (int c = 0; c < 8; c++) begin
      mrst = 1; loadEn = c[2]; presetSel = c[1:0]; modeSerial = 0;
      cyc();
      checkAll($sformatf("R1 code%0d", c), expPreset(c), expPreset(c), 0);
      idle();
    end

    // R2: serial mode chosen at reset, code 2 -> 31
    mrst = 1; modeSerial = 1; presetSel = 2'b10; loadEn = 0;
    cyc(); idle();
    modeSerial = 0;   // R2 late change must be ignored
    checkAll("R2 serial preset", 31, 31, 0);

    // R4: parallel write ignored in serial mode
    loadEn = 1; wrEn = 1; dataIn = 16'h0155;
    cyc(); idle();
    checkAll("R4 R2 parallel write in serial mode", 31, 31, 0);

    // R5: serial load, empty 421 then full 195, LSB first
    begin
      logic [OW-1:0] pe, pf;
      pe = 10'd421; pf = 10'd195;
      for (int k = 0; k < 2 * OW; k++) begin
        serEn = 1; serIn = (k < OW) ? pe[k] : pf[k - OW];
        cyc();
      end
      idle();
      checkAll("R5 serial load", 421, 195, 0);
    end

    // R8: read-back in serial mode
    loadEn = 1; rdEn = 1;
    cyc();
    checkAll("R8 serial read empty", 421, 195, 421);
    cyc();
    checkAll("R8 serial read full", 421, 195, 195);
    idle();

    // R10: partial reset keeps offsets and serial mode; read pointer returns to empty
    prst = 1;
    cyc(); idle();
    checkAll("R10 prst keeps offsets", 421, 195, 195);
    loadEn = 1; rdEn = 1;
    cyc(); idle();
    checkAll("R10 read after prst", 421, 195, 421);
    loadEn = 1; wrEn = 1; dataIn = 16'h0001;
    cyc(); idle();
    checkAll("R10 R4 mode kept after prst", 421, 195, 421);

    // R1: dataOut cleared by master reset
    mrst = 1; modeSerial = 0; presetSel = 2'b11; loadEn = 1;
    cyc(); idle();
    checkAll("R1 reset clears dataOut", 1023, 1023, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule